// File: doc/BRIEF.md
# DRAM Refresh Counter Self-Test Sequencer

This block sits on the controller side of a DRAM with a 4-bit data bus. It runs a built-in procedure that proves the device's internal refresh address counter steps through every row. It drives the row strobe, column strobe, write enable, output enable, the multiplexed address bus and the write data bus. It samples the read data bus at the end of each read strobe.

A run begins with a short burst of row-only refresh cycles that wake the device up. Three passes follow, all at one fixed column. The first pass writes a background pattern to every row, using explicit ascending row addresses. The second pass runs one counter-test cycle per row. In each one the column strobe is lowered before the row strobe, so the device chooses the row from its own counter. A second column strobe then reads the cell, checks it against the background, and writes back the inverse. The third pass reads every row again by explicit address and checks it against the inverse. The whole pass set is then repeated with the two patterns swapped.

A mismatch makes the result flag sticky and records where the first error happened, but the run always goes to completion. Strobe widths and precharge gaps are parameters counted in clock cycles.

Top module: `refctr_selftest`

## Requirements
- R1: A one-cycle `start` while `busy` is low begins a run, and `busy` is high in the cycle after that edge. A `start` while `busy` is high has no effect on the run.
- R2: A run begins with exactly N_INIT (default 8) row-only refresh cycles. In each one `ras_n` goes low and returns high while `cas_n` stays high throughout, and no column strobe occurs before the last of them.
- R3: Every falling edge of `cas_n` that occurs while `ras_n` is low presents the parameter TEST_COL on `addr`.
- R4: The write pass issues 2^ROW_BITS early writes (`cas_n` falls while `we_n` is already low), with rows 0 to 2^ROW_BITS-1 in ascending order. The data is 4'b0000 in round 0 and 4'b1111 in round 1.
- R5: The counter-test pass issues 2^ROW_BITS counter-test cycles. In each one `cas_n` is low before `ras_n` falls, `cas_n` rises while `ras_n` stays low, and `cas_n` falls again with `oe_n` low for a read. The read data is checked against the background. `we_n` then falls while `cas_n` is still low and writes the inverse of the background.
- R6: The read pass issues 2^ROW_BITS normal reads (`oe_n` low, `we_n` high), one per row. Each is checked against the inverse of that round's background.
- R7: Round 1 runs the write, counter-test and read passes again with the patterns swapped. A healthy run therefore leaves every row holding 4'b0000 and issues 2·2^ROW_BITS operations of each kind.
- R8: A mismatch sets `fail`, which stays set until the next start. `fail_row` and `fail_phase` hold the first mismatch. `fail_row` is the explicit row in a read pass and the loop index in a counter-test pass. `fail_phase` is {round, 1 if read pass / 0 if counter-test pass}. The run still completes.
- R9: After reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are high and `busy`, `done` and `fail` are low. At the end of a run `done` goes high and `busy` goes low, and both hold until the next start.
- R10: Each read or write column strobe holds `cas_n` low for T_CAS cycles or longer, with the shortest one lasting exactly T_CAS. `ras_n` is high for at least T_RP cycles between any two low periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| rdata | input | DW | Data read from the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ROW_BITS | Multiplexed row/column address |
| wdata | output | DW | Data written to the DRAM |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one mismatch in this run |
| fail_row | output | ROW_BITS | Row or loop index of the first mismatch |
| fail_phase | output | 2 | {round, read-pass} of the first mismatch |

## Verification
The hardest case to reach is a device whose refresh counter is broken. From the port side every row still looks addressable, so nothing seems wrong until the counter revisits a row it has already inverted. The device model in the bench can force one counter bit to zero. With bit 5 stuck, the 33rd counter-test cycle lands on row 0, which already holds the inverse, so the bench expects the first failure at loop index 32 in round 0. A second fault, a read data bit stuck low, only appears once cells hold all ones, so the first mismatch moves to row 0 of the round-0 read pass.

// File: rtl/refctr_pkg.sv
package refctr_pkg;

  typedef enum logic [1:0] {
    OP_RONLY = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_CTEST = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_CWR, ST_CRD, ST_PRE,
    ST_CBR_CAS, ST_CBR_RAS, ST_CT_PRE, ST_CT_RD, ST_CT_WR
  } step_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_INIT, PH_WRITE, PH_CTEST, PH_READ, PH_DONE
  } phase_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic col_sel;
  } strobe_t;

  function automatic step_e first_step(op_e op);
    return (op == OP_CTEST) ? ST_CBR_CAS : ST_ROW;
  endfunction

  function automatic step_e next_step(op_e op, step_e s);
    step_e n;
    case (s)
      ST_ROW:     n = (op == OP_RONLY) ? ST_PRE : ((op == OP_WRITE) ? ST_CWR : ST_CRD);
      ST_CWR:     n = ST_PRE;
      ST_CRD:     n = ST_PRE;
      ST_CBR_CAS: n = ST_CBR_RAS;
      ST_CBR_RAS: n = ST_CT_PRE;
      ST_CT_PRE:  n = ST_CT_RD;
      ST_CT_RD:   n = ST_CT_WR;
      ST_CT_WR:   n = ST_PRE;
      default:    n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic strobe_t decode(step_e s);
    strobe_t v;
    v.ras_n   = !(s inside {ST_ROW, ST_CWR, ST_CRD, ST_CBR_RAS, ST_CT_PRE, ST_CT_RD, ST_CT_WR});
    v.cas_n   = !(s inside {ST_CWR, ST_CRD, ST_CBR_CAS, ST_CBR_RAS, ST_CT_RD, ST_CT_WR});
    v.we_n    = !(s inside {ST_CWR, ST_CT_WR});
    v.oe_n    = !(s inside {ST_CRD, ST_CT_RD});
    v.col_sel =  (s inside {ST_CWR, ST_CRD, ST_CT_RD, ST_CT_WR});
    return v;
  endfunction

  function automatic op_e phase_op(phase_e p);
    op_e o;
    case (p)
      PH_WRITE: o = OP_WRITE;
      PH_CTEST: o = OP_CTEST;
      PH_READ:  o = OP_READ;
      default:  o = OP_RONLY;
    endcase
    return o;
  endfunction

  function automatic phase_e next_phase(phase_e p, logic round);
    phase_e n;
    case (p)
      PH_INIT:  n = PH_WRITE;
      PH_WRITE: n = PH_CTEST;
      PH_CTEST: n = PH_READ;
      PH_READ:  n = round ? PH_DONE : PH_WRITE;
      default:  n = PH_IDLE;
    endcase
    return n;
  endfunction

  // Fill bit of a pattern: background is the round number, inverse flips it.
  function automatic logic data_bit(logic round, logic inverse);
    return round ^ inverse;
  endfunction

  function automatic logic [1:0] fail_code(logic round, phase_e p);
    return {round, p == PH_READ};
  endfunction

endpackage

// File: rtl/refctr_cycle_gen.sv
module refctr_cycle_gen
  import refctr_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter logic [ROW_BITS-1:0] TEST_COL = '0,
  parameter int T_RCD = 1,
  parameter int T_CAS = 2,
  parameter int T_RP  = 1,
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_CP  = 1,
  parameter int T_WP  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  op_e                 op,
  input  logic [ROW_BITS-1:0] row,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [ROW_BITS-1:0] addr,
  output logic                idle,
  output logic                op_done,
  output logic                sample_ev
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = imax(imax(imax(T_RCD, T_CAS), imax(T_RP, T_CSR)),
                             imax(imax(T_CHR, T_CP), T_WP));
  localparam int TW = $clog2(TMAX + 1);

  function automatic logic [TW-1:0] step_len(step_e s);
    logic [TW-1:0] n;
    case (s)
      ST_ROW:                  n = TW'(T_RCD);
      ST_CWR, ST_CRD, ST_CT_RD: n = TW'(T_CAS);
      ST_PRE:                  n = TW'(T_RP);
      ST_CBR_CAS:              n = TW'(T_CSR);
      ST_CBR_RAS:              n = TW'(T_CHR);
      ST_CT_PRE:               n = TW'(T_CP);
      ST_CT_WR:                n = TW'(T_WP);
      default:                 n = TW'(1);
    endcase
    return n;
  endfunction

  step_e         step;
  op_e           cur_op;
  logic [TW-1:0] tmr;
  strobe_t       stb;
  logic          step_last;
  step_e         step_nx;

  assign step_last = (step != ST_IDLE) && (tmr == step_len(step) - TW'(1));
  assign step_nx   = next_step(cur_op, step);
  assign op_done   = step_last && (step_nx == ST_IDLE);
  assign sample_ev = step_last && (step inside {ST_CRD, ST_CT_RD});
  assign idle      = (step == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      cur_op <= OP_RONLY;
      tmr    <= '0;
    end else if (step == ST_IDLE) begin
      if (go) begin
        step   <= first_step(op);
        cur_op <= op;
        tmr    <= '0;
      end
    end else if (step_last) begin
      step <= step_nx;
      tmr  <= '0;
    end else begin
      tmr <= tmr + TW'(1);
    end
  end

  assign stb   = decode(step);
  assign ras_n = stb.ras_n;
  assign cas_n = stb.cas_n;
  assign we_n  = stb.we_n;
  assign oe_n  = stb.oe_n;
  assign addr  = stb.col_sel ? TEST_COL : row;

  // R3: the column strobe always carries the fixed test column
  p_fixed_column_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (addr == TEST_COL));

  // R5: a CAS-before-RAS edge only appears inside a counter-test cycle
  p_cbr_in_ctest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> (cur_op == OP_CTEST));

  // R5: the modify write of a counter-test cycle follows straight after the check
  p_rmw_after_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && cur_op == OP_CTEST) |-> $past(sample_ev));

  // R6: read data is taken only inside an open read window
  p_sample_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |-> (!ras_n && !cas_n && !oe_n && we_n));

endmodule

// File: rtl/refctr_fail_log.sv
module refctr_fail_log #(
  parameter int ROW_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                hit,
  input  logic [ROW_BITS-1:0] row_in,
  input  logic [1:0]          code_in,
  output logic                fail,
  output logic [ROW_BITS-1:0] fail_row,
  output logic [1:0]          fail_phase
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail       <= 1'b0;
      fail_row   <= '0;
      fail_phase <= '0;
    end else if (clear) begin
      fail       <= 1'b0;
      fail_row   <= '0;
      fail_phase <= '0;
    end else if (hit && !fail) begin
      fail       <= 1'b1;
      fail_row   <= row_in;
      fail_phase <= code_in;
    end
  end

  // R8: once set, the flag and the first location stay put until cleared
  p_first_fail_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> (fail && $stable(fail_row) && $stable(fail_phase)));

endmodule

// File: rtl/refctr_selftest.sv
module refctr_selftest
  import refctr_pkg::*;
#(
  parameter int ROW_BITS = 10,
  parameter int DW       = 4,
  parameter int N_INIT   = 8,
  parameter logic [ROW_BITS-1:0] TEST_COL = ROW_BITS'(341),
  parameter int T_RCD = 1,
  parameter int T_CAS = 2,
  parameter int T_RP  = 1,
  parameter int T_CSR = 1,
  parameter int T_CHR = 1,
  parameter int T_CP  = 1,
  parameter int T_WP  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DW-1:0]       rdata,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n,
  output logic [ROW_BITS-1:0] addr,
  output logic [DW-1:0]       wdata,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [ROW_BITS-1:0] fail_row,
  output logic [1:0]          fail_phase
);

  localparam logic [ROW_BITS-1:0] ROW_LAST  = '1;
  localparam logic [ROW_BITS-1:0] INIT_LAST = ROW_BITS'(N_INIT - 1);

  phase_e              phase;
  logic                round;
  logic [ROW_BITS-1:0] idx;
  logic [ROW_BITS-1:0] idx_last;
  logic                gen_idle, gen_done, sample_ev;
  logic                go, launch, mismatch;
  logic [DW-1:0]       exp_data;

  assign busy     = (phase != PH_IDLE) && (phase != PH_DONE);
  assign done     = (phase == PH_DONE);
  assign launch   = start && !busy;
  assign go       = busy && gen_idle;
  assign idx_last = (phase == PH_INIT) ? INIT_LAST : ROW_LAST;
  assign wdata    = {DW{data_bit(round, phase == PH_CTEST)}};
  assign exp_data = {DW{data_bit(round, phase == PH_READ)}};
  assign mismatch = sample_ev && (rdata != exp_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      round <= 1'b0;
      idx   <= '0;
    end else if (launch) begin
      phase <= PH_INIT;
      round <= 1'b0;
      idx   <= '0;
    end else if (gen_done) begin
      if (idx == idx_last) begin
        idx   <= '0;
        phase <= next_phase(phase, round);
        if (phase == PH_READ) round <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  refctr_cycle_gen #(
    .ROW_BITS(ROW_BITS), .TEST_COL(TEST_COL),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR),
    .T_CHR(T_CHR), .T_CP(T_CP), .T_WP(T_WP)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .go(go), .op(phase_op(phase)), .row(idx),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .idle(gen_idle), .op_done(gen_done), .sample_ev(sample_ev)
  );

  refctr_fail_log #(.ROW_BITS(ROW_BITS)) u_log (
    .clk(clk), .rst_n(rst_n), .clear(launch), .hit(mismatch),
    .row_in(idx), .code_in(fail_code(round, phase)),
    .fail(fail), .fail_row(fail_row), .fail_phase(fail_phase)
  );

  // R1: a start while busy leaves the pass and its index untouched
  p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !gen_done) |=> (idx == $past(idx) && phase == $past(phase)));

  // R9: busy and done never overlap
  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7: completion is reached only from the read pass of the second round
  p_two_rounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(round) && $past(phase) == PH_READ));

endmodule

// File: tb/refctr_selftest_test.sv
module refctr_selftest_test;
  localparam int CLK_P    = 10;
  localparam int ROWS     = 1024;
  localparam int T_CAS    = 3;
  localparam int T_RP     = 2;
  localparam logic [9:0] COL = 10'd341;
  localparam int WD_LIMIT = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] rdata;
  logic       ras_n, cas_n, we_n, oe_n, busy, done, fail;
  logic [9:0] addr, fail_row;
  logic [3:0] wdata;
  logic [1:0] fail_phase;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #(CLK_P/2) clk = ~clk;

  refctr_selftest #(.T_CAS(T_CAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rdata(rdata),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .fail(fail),
    .fail_row(fail_row), .fail_phase(fail_phase)
  );

  // ---------------- DRAM model ----------------
  logic [3:0] mem [ROWS];
  logic [9:0] m_row, m_cnt, last_wr;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic cbr, cas_in_ras, cas_seen, data_cas;
  logic fault_cnt5, fault_d2;
  int n_ronly, n_ronly_pre, n_cbr, n_ewrite, n_rmw, n_read, n_ctread;
  int n_col_err, n_order_err, ras_hi, min_gap, cas_lo, min_cas;

  assign rdata = fault_d2 ? (mem[m_row] & 4'hB) : mem[m_row];

  always @(posedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (ras_hi < min_gap) min_gap = ras_hi;
        ras_hi = 0;
        cas_in_ras = 1'b0;
        if (cas_n) begin
          m_row <= addr;
          cbr = 1'b0;
        end else begin
          m_row <= fault_cnt5 ? (m_cnt & ~10'h020) : m_cnt;
          m_cnt <= m_cnt + 10'd1;
          n_cbr++;
          cbr = 1'b1;
        end
      end else if (ras_n) begin
        ras_hi++;
      end
      if (p_cas && !cas_n && !ras_n) begin
        cas_seen = 1'b1;
        cas_in_ras = 1'b1;
        data_cas = 1'b1;
        cas_lo = 1;
        if (addr != COL) n_col_err++;
        if (!we_n) begin
          mem[m_row] <= wdata;
          n_ewrite++;
          if (m_row != last_wr + 10'd1) n_order_err++;
          last_wr = m_row;
        end else if (!oe_n) begin
          if (cbr) n_ctread++; else n_read++;
        end
      end else if (!cas_n && data_cas) begin
        cas_lo++;
      end
      if (!p_cas && cas_n) begin
        if (data_cas && cas_lo < min_cas) min_cas = cas_lo;
        data_cas = 1'b0;
      end
      if (p_we && !we_n && !p_cas && !cas_n && !ras_n) begin
        mem[m_row] <= wdata;
        n_rmw++;
      end
      if (!p_ras && ras_n) begin
        if (!cas_in_ras && !cbr) begin
          n_ronly++;
          if (!cas_seen) n_ronly_pre++;
        end
        cbr = 1'b0;
      end
    end
    p_ras = ras_n;
    p_cas = cas_n;
    p_we  = we_n;
  end

  task automatic model_clear(input logic [9:0] cnt0, input logic f_cnt, input logic f_dat);
    for (int i = 0; i < ROWS; i++) mem[i] = 4'h5;
    m_row = '0; m_cnt = cnt0; last_wr = 10'h3FF;
    cbr = 0; cas_in_ras = 0; cas_seen = 0; data_cas = 0;
    fault_cnt5 = f_cnt; fault_d2 = f_dat;
    n_ronly = 0; n_ronly_pre = 0; n_cbr = 0; n_ewrite = 0; n_rmw = 0;
    n_read = 0; n_ctread = 0; n_col_err = 0; n_order_err = 0;
    ras_hi = 0; min_gap = 1000000; cas_lo = 0; min_cas = 1000000;
  endtask

  // ---------------- checking ----------------
  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R9", "strobes idle high after reset",
        {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!busy && !done, "R9", "busy/done low after reset", {busy, done}, 0);
    chk(!fail, "R9", "fail low after reset", fail, 0);
  endtask

  task automatic t_healthy();
    int zeros;
    model_clear(10'd37, 1'b0, 1'b0);
    pulse_start();
    chk(busy, "R1", "busy one cycle after start", busy, 1);
    repeat (100) @(negedge clk);
    pulse_start(); // R1: must be ignored while busy
    wait_done();
    chk(!fail, "R8", "healthy run has no fail", fail, 0);
    chk(done && !busy, "R9", "done high busy low at end", {done, busy}, 2);
    chk(n_ronly_pre == 8 && n_ronly == 8, "R2", "row-only refresh cycles", n_ronly_pre, 8);
    chk(n_col_err == 0, "R3", "column strobes with wrong column", n_col_err, 0);
    chk(n_ewrite == 2*ROWS, "R4", "early writes (also R1 no restart)", n_ewrite, 2*ROWS);
    chk(n_order_err == 0, "R4", "write rows out of order", n_order_err, 0);
    chk(n_cbr == 2*ROWS && n_ctread == 2*ROWS, "R5", "counter-test cycles", n_cbr, 2*ROWS);
    chk(n_rmw == 2*ROWS, "R5", "read-modify-write writes", n_rmw, 2*ROWS);
    chk(n_read == 2*ROWS, "R6", "normal reads", n_read, 2*ROWS);
    zeros = 0;
    for (int i = 0; i < ROWS; i++) if (mem[i] == 4'h0) zeros++;
    chk(zeros == ROWS, "R7", "rows holding zero after round 1", zeros, ROWS);
    chk(min_cas == T_CAS, "R10", "shortest data CAS low", min_cas, T_CAS);
    chk(min_gap >= T_RP, "R10", "shortest RAS precharge", min_gap, T_RP);
    repeat (5) @(negedge clk);
    chk(done && !busy, "R9", "done holds until next start", {done, busy}, 2);
  endtask

  task automatic t_stuck_counter();
    model_clear(10'd0, 1'b1, 1'b0);
    pulse_start();
    chk(!fail && !done, "R8", "fail and done cleared by start", {fail, done}, 0);
    wait_done();
    chk(fail, "R8", "stuck counter bit flagged", fail, 1);
    chk(fail_row == 10'd32, "R8", "first fail loop index", fail_row, 32);
    chk(fail_phase == 2'b00, "R8", "first fail in round 0 counter pass", fail_phase, 0);
    chk(n_ewrite == 2*ROWS, "R8", "run completes after fail", n_ewrite, 2*ROWS);
  endtask

  task automatic t_data_fault();
    model_clear(10'd500, 1'b0, 1'b1);
    pulse_start();
    wait_done();
    chk(fail, "R6", "stuck data bit flagged", fail, 1);
    chk(fail_row == 10'd0, "R6", "first failing row in read pass", fail_row, 0);
    chk(fail_phase == 2'b01, "R8", "first fail in round 0 read pass", fail_phase, 1);
  endtask

  initial begin
    model_clear(10'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_healthy();
    t_stuck_counter();
    t_data_fault();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule